// File: doc/BRIEF.md
# Configuration Type 1 to Type 0 Address Translator

This block sits at the downstream face of a bus bridge. When a configuration access travels from the upstream bus to a device on the downstream bus, it comes in with the hierarchical (Type 1) address format. In that format a 5-bit device number sits at bits 15:11. The block rewrites the address into the local (Type 0) format. Each low device number becomes a single select line in the upper half of the outgoing word. A reserved device number combined with a zero register field becomes a special-cycle request instead of a configuration access.

The block samples the address word when the address-phase strobe is high and a flag shows whether the access targets the downstream bus. One clock later it presents the registered result with an address-valid pulse. For a generated Type 0 configuration access, the start-of-frame permission pulse comes one clock after the address-valid pulse. This extra clock lets resistively coupled select lines settle. Pass-through addresses and special cycles receive the permission pulse in the same clock as the address. The outgoing address and the special-cycle flag hold their values until the next strobe.

Top module: `cfg_t1_xlate`

## Requirements
- R1: After reset, `out_addr` is zero and `addr_vld`, `frame_go` and `spec_cyc` are all low.
- R2: With `to_sec` high and device number `d = in_addr[15:11]` in 0..15, `out_addr[31:16]` has exactly one bit set, bit `16+d`, one clock after the strobe.
- R3: With `to_sec` high and `d` in 16..30, `out_addr[31:16]` is all zero, the access is still forwarded (`addr_vld` pulses) and `spec_cyc` is low.
- R4: With `to_sec` high, `d = 31` and `in_addr[7:2] = 0`, `spec_cyc` is high one clock after the strobe.
- R5: With `to_sec` high, `d = 31` and `in_addr[7:2] != 0`, `out_addr[31:16]` is zero and `spec_cyc` is low.
- R6: With `to_sec` high, `out_addr[1:0]` is `00` (the Type 0 marker) and `out_addr[15:2]` equals `in_addr[15:2]`.
- R7: With `to_sec` low, `out_addr` equals `in_addr` unchanged, `spec_cyc` is low and `frame_go` pulses in the same clock as `addr_vld`.
- R8: For a generated Type 0 configuration access (R2, R3, R5), `addr_vld` pulses one clock after the strobe, `frame_go` stays low in that clock and pulses in the next one, and `out_addr` does not change between the two clocks.
- R9: A special cycle (R4) is not stepped: `frame_go` pulses in the same clock as `addr_vld`.
- R10: `out_addr` and `spec_cyc` hold their values in every clock that follows a cycle without a strobe. `addr_vld` and `frame_go` are single-clock pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_addr | input | 32 | Incoming address word of the configuration access |
| addr_stb | input | 1 | High for one clock in the address phase |
| to_sec | input | 1 | High when the access targets the downstream bus and must be translated |
| out_addr | output | 32 | Registered outgoing address word |
| spec_cyc | output | 1 | Registered special-cycle request |
| addr_vld | output | 1 | One-clock pulse: `out_addr` has just been loaded |
| frame_go | output | 1 | One-clock pulse: the frame may start |

## Verification
The bench targets the decode boundaries: device 15 against device 16, and device 31 with a zero register field against device 31 with a one-bit register field. A design with an off-by-one decode would raise a select bit for device 16, and one that ignores the register field would raise a special cycle for every device 31 access. The bench also measures the gap between `addr_vld` and `frame_go` for each kind of access. A stepping error would let a frame start before the select line settles, or would delay pass-through traffic. Back-to-back strobes and idle gaps test whether the registered word holds its value or drifts.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

  localparam int DEV_LSB = 11;
  localparam int DEV_W   = 5;
  localparam int REG_LSB = 2;
  localparam int REG_W   = 6;

  // Device number field of a hierarchical configuration address.
  function automatic logic [DEV_W-1:0] dev_of(input logic [31:0] a);
    return a[DEV_LSB +: DEV_W];
  endfunction

  // Register field (double-word index) of the address.
  function automatic logic [REG_W-1:0] reg_of(input logic [31:0] a);
    return a[REG_LSB +: REG_W];
  endfunction

  // Reserved device number with a zero register field asks for a special cycle.
  function automatic logic wants_special(input logic [31:0] a);
    return (dev_of(a) == {DEV_W{1'b1}}) && (reg_of(a) == '0);
  endfunction

endpackage

// File: rtl/cfgx_decode.sv
module cfgx_decode
  import cfgx_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int IDSEL_LSB = 16,
  parameter int IDSEL_CNT = 16
) (
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              to_sec,
  output logic [ADDR_W-1:0] xl_addr,
  output logic              xl_spec,
  output logic              xl_step
);
  localparam int UP_W = ADDR_W - IDSEL_LSB;

  logic [DEV_W-1:0] dev;
  logic [UP_W-1:0]  sel;
  logic             spec_hit;

  assign dev      = dev_of(in_addr[31:0]);
  assign spec_hit = wants_special(in_addr[31:0]);

  // One comparator per select line; lines past the decoded range stay low.
  for (genvar g = 0; g < UP_W; g++) begin : g_sel
    if (g < IDSEL_CNT) begin : g_live
      assign sel[g] = (dev == DEV_W'(g));
    end else begin : g_dead
      assign sel[g] = 1'b0;
    end
  end

  always_comb begin
    if (to_sec) begin
      xl_addr = {sel, in_addr[IDSEL_LSB-1:2], 2'b00};
      xl_spec = spec_hit;
      xl_step = !spec_hit;
    end else begin
      xl_addr = in_addr;
      xl_spec = 1'b0;
      xl_step = 1'b0;
    end
  end

endmodule

// File: rtl/cfgx_hold.sv
module cfgx_hold #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] nxt_addr,
  input  logic              nxt_spec,
  output logic [ADDR_W-1:0] out_addr,
  output logic              spec_cyc
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_addr <= '0;
      spec_cyc <= 1'b0;
    end else if (load) begin
      out_addr <= nxt_addr;
      spec_cyc <= nxt_spec;
    end
  end
endmodule

// File: rtl/cfgx_step.sv
module cfgx_step (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic need_step,
  output logic addr_vld,
  output logic frame_go,
  output logic step_pend
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_vld  <= 1'b0;
      frame_go  <= 1'b0;
      step_pend <= 1'b0;
    end else if (start) begin
      addr_vld  <= 1'b1;
      frame_go  <= !need_step;
      step_pend <= need_step;
    end else begin
      addr_vld  <= 1'b0;
      frame_go  <= step_pend;
      step_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_t1_xlate.sv
module cfg_t1_xlate #(
  parameter int ADDR_W    = 32,
  parameter int IDSEL_LSB = 16,
  parameter int IDSEL_CNT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              addr_stb,
  input  logic              to_sec,
  output logic [ADDR_W-1:0] out_addr,
  output logic              spec_cyc,
  output logic              addr_vld,
  output logic              frame_go
);
  logic [ADDR_W-1:0] xl_addr;
  logic              xl_spec;
  logic              xl_step;
  logic              step_pend;

  cfgx_decode #(
    .ADDR_W(ADDR_W), .IDSEL_LSB(IDSEL_LSB), .IDSEL_CNT(IDSEL_CNT)
  ) u_dec (
    .in_addr(in_addr), .to_sec(to_sec),
    .xl_addr(xl_addr), .xl_spec(xl_spec), .xl_step(xl_step)
  );

  cfgx_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(addr_stb),
    .nxt_addr(xl_addr), .nxt_spec(xl_spec),
    .out_addr(out_addr), .spec_cyc(spec_cyc)
  );

  cfgx_step u_step (
    .clk(clk), .rst_n(rst_n), .start(addr_stb), .need_step(xl_step),
    .addr_vld(addr_vld), .frame_go(frame_go), .step_pend(step_pend)
  );

endmodule

// File: rtl/cfgx_chk.sv
module cfgx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] in_addr,
  input logic        addr_stb,
  input logic        to_sec,
  input logic [31:0] out_addr,
  input logic        spec_cyc,
  input logic        addr_vld,
  input logic        frame_go,
  input logic        step_pend
);
  logic low_dev, spec_req;
  assign low_dev  = (in_addr[15:11] < 5'd16);
  assign spec_req = (in_addr[15:11] == 5'd31) && (in_addr[7:2] == 6'd0);

  a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    addr_stb && to_sec && low_dev |=> $countones(out_addr[31:16]) == 1);

  a_r4_special: assert property (@(posedge clk) disable iff (!rst_n)
    addr_stb && to_sec && spec_req |=> spec_cyc);

  a_r6_type0_mark: assert property (@(posedge clk) disable iff (!rst_n)
    addr_stb && to_sec |=> out_addr[1:0] == 2'b00);

  a_r7_pass: assert property (@(posedge clk) disable iff (!rst_n)
    addr_stb && !to_sec |=> out_addr == $past(in_addr) && !spec_cyc && frame_go);

  a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld && !frame_go && !addr_stb |=> frame_go && $stable(out_addr));

  a_r9_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld && spec_cyc |-> frame_go);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_stb |=> $stable(out_addr) && $stable(spec_cyc) && !addr_vld);

  a_r10_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
    step_pend |=> !step_pend || addr_vld);
endmodule

bind cfg_t1_xlate cfgx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_addr(in_addr), .addr_stb(addr_stb),
  .to_sec(to_sec), .out_addr(out_addr), .spec_cyc(spec_cyc),
  .addr_vld(addr_vld), .frame_go(frame_go), .step_pend(step_pend)
);

// File: tb/test_cfg_t1_xlate.sv
`timescale 1ns/1ps
module test_cfg_t1_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] in_addr = '0;
  logic        addr_stb = 1'b0;
  logic        to_sec = 1'b0;
  logic [31:0] out_addr;
  logic        spec_cyc, addr_vld, frame_go;

  int n_run = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cfg_t1_xlate i_cfg_t1_xlate (
    .clk(clk), .rst_n(rst_n), .in_addr(in_addr), .addr_stb(addr_stb),
    .to_sec(to_sec), .out_addr(out_addr), .spec_cyc(spec_cyc),
    .addr_vld(addr_vld), .frame_go(frame_go)
  );

  // Bench model: select line built by a search loop, not by decode.
  function automatic logic [31:0] model_addr(logic [31:0] a, logic sec);
    logic [15:0] up = '0;
    int d = int'(a[15:11]);
    if (!sec) return a;
    for (int k = 0; k < 16; k++) if (k == d) up[k] = 1'b1;
    return {up, a[15:2], 2'b00};
  endfunction

  function automatic logic model_spec(logic [31:0] a, logic sec);
    return sec && (int'(a[15:11]) == 31) && (int'(a[7:2]) == 0);
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(logic [31:0] a, logic sec);
    int d = int'(a[15:11]);
    if (!sec) return "R7";
    if (d < 16) return "R2";
    if (d < 31) return "R3";
    if (a[7:2] == 0) return "R4";
    return "R5";
  endfunction

  task automatic xfer(logic [31:0] a, logic sec, int gap);
    logic [31:0] ea = model_addr(a, sec);
    logic        es = model_spec(a, sec);
    logic        stp = sec && !es;
    string       t = tag_of(a, sec);
    @(negedge clk);
    in_addr = a; to_sec = sec; addr_stb = 1'b1;
    @(negedge clk);
    addr_stb = 1'b0; in_addr = $urandom; to_sec = $urandom_range(0, 1);
    chk(out_addr == ea, {t, " addr"}, out_addr, ea);
    chk(spec_cyc == es, {t, " spec"}, 32'(spec_cyc), 32'(es));
    if (sec) chk(out_addr[1:0] == 2'b00 && out_addr[15:2] == a[15:2], "R6 low bits", out_addr, ea);
    chk(addr_vld == 1'b1, "R8 addr_vld pulse", 32'(addr_vld), 1);
    chk(frame_go == !stp, stp ? "R8 no early frame" : (es ? "R9 frame" : "R7 frame"),
        32'(frame_go), 32'(!stp));
    @(negedge clk);
    chk(addr_vld == 1'b0, "R10 addr_vld single", 32'(addr_vld), 0);
    chk(frame_go == stp, stp ? "R8 stepped frame" : "R10 frame single", 32'(frame_go), 32'(stp));
    chk(out_addr == ea, "R8 stable addr", out_addr, ea);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      chk(out_addr == ea && spec_cyc == es, "R10 hold", out_addr, ea);
      chk(!addr_vld && !frame_go, "R10 idle pulses", {30'd0, addr_vld, frame_go}, 0);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_run++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    chk(out_addr == 0 && !spec_cyc && !addr_vld && !frame_go, "R1 reset",
        {out_addr[31:3], spec_cyc, addr_vld, frame_go}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_addr == 0 && !addr_vld && !frame_go, "R1 after reset", out_addr, 0);
    // Directed corners.
    for (int d = 0; d < 32; d++) xfer({16'hABCD, 5'(d), 3'b101, 6'h15, 2'b01}, 1'b1, 1);
    xfer({16'h1234, 5'd15, 3'd0, 6'd0, 2'b01}, 1'b1, 0);   // R2 top device
    xfer({16'h1234, 5'd16, 3'd0, 6'd0, 2'b01}, 1'b1, 0);   // R3 first out of range
    xfer({16'h0000, 5'd31, 3'd7, 6'd0, 2'b01}, 1'b1, 2);   // R4 special
    xfer({16'h0000, 5'd31, 3'd0, 6'd1, 2'b01}, 1'b1, 2);   // R5 reg nonzero
    xfer(32'hDEAD_BEEF, 1'b0, 2);                          // R7 pass-through
    xfer({16'hFFFF, 5'd31, 3'd0, 6'd0, 2'b11}, 1'b0, 0);   // R7 no special upstream
    // Random mix.
    for (int i = 0; i < 300; i++)
      xfer($urandom, 1'(($urandom_range(0, 3)) != 0), $urandom_range(0, 2));
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule